// File: doc/BRIEF.md
# Boot flash address window decoder

This block turns a 32-bit processor address into a chip select for the boot flash. The address is compared against a small set of programmable address windows and against one bank compare made of a base and a mask. The block also gives the fetch address that the processor uses for its first instruction after reset. A strap input picks one of two boot spaces. It sets the reset placement of window 0 and of the bank compare, and it sets the reset fetch address. The block holds the strap value from reset onward.

Early boot code uses the write port to move the flash. A typical sequence runs in four steps:

1. Clear the bank mask, so that the flash answers at every address.
2. Open window 1 at the final flash base.
3. Jump to that base.
4. Reprogram window 0 and the bank compare, then switch window 1 off by writing zero to it.

The window compare and the bank compare are combinational. A register write takes effect from the next clock edge.

Top module: `boot_law_decoder`

## Requirements
- R1: `fetch_vec_o` is 0x0000_0100 when `boot_hi_i` was 0 during reset, and 0xFFF0_0100 when it was 1. The value does not change until the next reset.
- R2: After reset, window 0 is enabled with 8 MB size code 0x16. For boot space 0 it covers 0x0000_0000 to 0x007F_FFFF, so 0x0080_0000 misses. For boot space 1 it covers 0xFF80_0000 to 0xFFFF_FFFF, so 0xFF7F_FFFF misses.
- R3: A window attribute holds an enable in bit 31 and a size code in bits 4:0. Code c maps 2^(c+1) bytes, so 0x13 maps 1 MB and 0x17 maps 16 MB. A code below 0x13, or a clear enable bit, gives no hit.
- R4: A window hits when the address bits at and above bit (c+1) equal the matching bits of its base. The window base is taken from write data bits 31:12. Base bits below the window size have no effect.
- R5: Writing zero to a window's base and attribute switches that window off.
- R6: When more than one window hits, the window with the lowest index wins. `win_idx_o` gives that index while `win_hit_o` is 1.
- R7: The bank compare uses only address bits 31:15. The bank base is taken from write data bits 31:15, and the bank mask from bits 31:15 of the bank option. The low 15 bits written to either register have no effect.
- R8: A bank mask of zero makes the bank match every address, so the flash appears at every address that a window covers.
- R9: `cs_o` is 1 only when some window hits and the bank compare matches. In every other case `no_hit_o` is 1.
- R10: Register selects:

  | Select | Register |
  |---|---|
  | 0 | window 0 base |
  | 1 | window 0 attribute |
  | 2 | window 1 base |
  | 3 | window 1 attribute |
  | 4 | bank base |
  | 5 | bank option |

  A write changes the decode from the next clock edge. In the cycle of the write, the decode still uses the old value.
- R11: At reset, window 1 is off. The bank base equals the window 0 reset base, and the bank mask is 0xFF80_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| boot_hi_i | input | 1 | Boot space strap, loaded during reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select (see R10) |
| wr_data_i | input | 32 | Register write data |
| addr_i | input | 32 | Address to decode |
| win_hit_o | output | 1 | Some enabled window covers the address |
| win_idx_o | output | 1 | Index of the winning window |
| cs_o | output | 1 | Flash chip select |
| no_hit_o | output | 1 | Address not routed to flash |
| fetch_vec_o | output | 32 | Reset instruction fetch address |

## Verification
Decode and reprogramming can fall in the same cycle. This matters most during the step in which boot code disables the window it is still fetching through. The bench drives a write of zero to the window 0 attribute while it holds an address inside window 0. It expects the hit and the chip select to stay 1 during that cycle and to drop after the next clock edge. A behavioural reference model, updated on every clock edge and compared every cycle, also checks the cycles in which a bank-mask or window write overlaps a decode.

// File: rtl/boot_law_pkg.sv
package boot_law_pkg;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned BASE_LSB = 12;
  localparam int unsigned BASE_W   = ADDR_W - BASE_LSB;
  localparam int unsigned BANK_LSB = 15;
  localparam int unsigned BANK_W   = ADDR_W - BANK_LSB;
  localparam int unsigned CODE_W   = 5;
  localparam int unsigned EN_BIT   = 31;

  localparam logic [ADDR_W-1:0] BOOT_WIN_BYTES = 32'h0080_0000;
  localparam logic [ADDR_W-1:0] HI_BOOT_ADDR   = 32'hFF80_0000;
  localparam logic [ADDR_W-1:0] FETCH_OFFSET   = 32'h0000_0100;
  localparam logic [ADDR_W-1:0] HI_FETCH_PAGE  = 32'hFFF0_0000;
  localparam logic [ADDR_W-1:0] LO_FETCH       = FETCH_OFFSET;
  localparam logic [ADDR_W-1:0] HI_FETCH       = HI_FETCH_PAGE | FETCH_OFFSET;
  localparam logic [ADDR_W-1:0] RST_MASK_ADDR  = ~(BOOT_WIN_BYTES - 32'd1);

  // size code c maps 2^(c+1) bytes
  localparam logic [CODE_W-1:0] MIN_CODE = CODE_W'(20 - 1);
  localparam logic [CODE_W-1:0] RST_CODE = CODE_W'($clog2(BOOT_WIN_BYTES) - 1);

  typedef struct packed {
    logic              en;
    logic [CODE_W-1:0] code;
    logic [BASE_W-1:0] base;
  } win_cfg_t;
endpackage

// File: rtl/law_cfg_regs.sv
module law_cfg_regs
  import boot_law_pkg::*;
#(
  parameter int unsigned WIN_NUM = 2,
  parameter int unsigned SEL_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              boot_hi_i,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  output win_cfg_t          win_cfg_o [WIN_NUM],
  output logic [BANK_W-1:0] bank_base_o,
  output logic [BANK_W-1:0] bank_mask_o,
  output logic              boot_hi_o
);
  localparam logic [SEL_W-1:0] SEL_BBASE = SEL_W'(2 * WIN_NUM);
  localparam logic [SEL_W-1:0] SEL_BOPT  = SEL_W'(2 * WIN_NUM + 1);

  logic unused_data;
  assign unused_data = ^wr_data_i[BASE_LSB-1:CODE_W];

  for (genvar i = 0; i < WIN_NUM; i++) begin : g_win
    localparam logic [SEL_W-1:0] SEL_BASE = SEL_W'(2 * i);
    localparam logic [SEL_W-1:0] SEL_ATTR = SEL_W'(2 * i + 1);
    win_cfg_t cfg_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        if (i == 0) begin
          cfg_q.en   <= 1'b1;
          cfg_q.code <= RST_CODE;
          cfg_q.base <= boot_hi_i ? HI_BOOT_ADDR[ADDR_W-1:BASE_LSB] : '0;
        end else begin
          cfg_q <= '0;
        end
      end else if (wr_en_i) begin
        if (wr_sel_i == SEL_BASE) cfg_q.base <= wr_data_i[ADDR_W-1:BASE_LSB];
        if (wr_sel_i == SEL_ATTR) begin
          cfg_q.en   <= wr_data_i[EN_BIT];
          cfg_q.code <= wr_data_i[CODE_W-1:0];
        end
      end
    end

    assign win_cfg_o[i] = cfg_q;
  end

  logic [BANK_W-1:0] bank_base_q, bank_mask_q;
  logic              boot_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_base_q <= boot_hi_i ? HI_BOOT_ADDR[ADDR_W-1:BANK_LSB] : '0;
      bank_mask_q <= RST_MASK_ADDR[ADDR_W-1:BANK_LSB];
      boot_hi_q   <= boot_hi_i;
    end else if (wr_en_i) begin
      if (wr_sel_i == SEL_BBASE) bank_base_q <= wr_data_i[ADDR_W-1:BANK_LSB];
      if (wr_sel_i == SEL_BOPT)  bank_mask_q <= wr_data_i[ADDR_W-1:BANK_LSB];
    end
  end

  assign bank_base_o = bank_base_q;
  assign bank_mask_o = bank_mask_q;
  assign boot_hi_o   = boot_hi_q;
endmodule

// File: rtl/law_win_match.sv
module law_win_match
  import boot_law_pkg::*;
(
  input  win_cfg_t          cfg_i,
  input  logic [BASE_W-1:0] page_i,
  output logic              hit_o
);
  logic [5:0] size_lg;
  logic       valid;
  logic       mism;

  assign size_lg = {1'b0, cfg_i.code} + 6'd1;
  assign valid   = cfg_i.en && (cfg_i.code >= MIN_CODE);

  // compare only bits at or above the window size
  always_comb begin
    mism = 1'b0;
    for (int b = 0; b < BASE_W; b++) begin
      if ((b + BASE_LSB) >= int'(size_lg) && page_i[b] != cfg_i.base[b]) mism = 1'b1;
    end
  end

  assign hit_o = valid && !mism;
endmodule

// File: rtl/law_bank_match.sv
module law_bank_match
  import boot_law_pkg::*;
(
  input  logic [BANK_W-1:0] page_i,
  input  logic [BANK_W-1:0] base_i,
  input  logic [BANK_W-1:0] mask_i,
  output logic              match_o
);
  assign match_o = ((page_i ^ base_i) & mask_i) == '0;
endmodule

// File: rtl/boot_law_decoder.sv
module boot_law_decoder
  import boot_law_pkg::*;
#(
  parameter  int unsigned WIN_NUM = 2,
  localparam int unsigned SEL_W   = $clog2(2 * WIN_NUM + 2),
  localparam int unsigned IDX_W   = (WIN_NUM > 1) ? $clog2(WIN_NUM) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              boot_hi_i,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [31:0]       wr_data_i,
  input  logic [31:0]       addr_i,
  output logic              win_hit_o,
  output logic [IDX_W-1:0]  win_idx_o,
  output logic              cs_o,
  output logic              no_hit_o,
  output logic [31:0]       fetch_vec_o
);
  win_cfg_t          win_cfg [WIN_NUM];
  logic [BANK_W-1:0] bank_base, bank_mask;
  logic              boot_hi_q;
  logic [WIN_NUM-1:0] win_hit_vec;
  logic              bank_hit;
  logic              unused_addr;

  assign unused_addr = ^addr_i[BASE_LSB-1:0];

  law_cfg_regs #(.WIN_NUM(WIN_NUM), .SEL_W(SEL_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .boot_hi_i  (boot_hi_i),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .win_cfg_o  (win_cfg),
    .bank_base_o(bank_base),
    .bank_mask_o(bank_mask),
    .boot_hi_o  (boot_hi_q)
  );

  for (genvar i = 0; i < WIN_NUM; i++) begin : g_match
    law_win_match u_win (
      .cfg_i (win_cfg[i]),
      .page_i(addr_i[ADDR_W-1:BASE_LSB]),
      .hit_o (win_hit_vec[i])
    );
  end

  law_bank_match u_bank (
    .page_i (addr_i[ADDR_W-1:BANK_LSB]),
    .base_i (bank_base),
    .mask_i (bank_mask),
    .match_o(bank_hit)
  );

  // lowest index wins
  always_comb begin
    win_idx_o = '0;
    for (int i = WIN_NUM - 1; i >= 0; i--) begin
      if (win_hit_vec[i]) win_idx_o = IDX_W'(i);
    end
  end

  assign win_hit_o   = |win_hit_vec;
  assign cs_o        = win_hit_o && bank_hit;
  assign no_hit_o    = !cs_o;
  assign fetch_vec_o = boot_hi_q ? HI_FETCH : LO_FETCH;
endmodule

// File: rtl/boot_law_chk.sv
module boot_law_chk #(
  parameter int unsigned WIN_NUM = 2,
  parameter int unsigned SEL_W   = 3,
  parameter int unsigned IDX_W   = 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [SEL_W-1:0]   wr_sel_i,
  input logic [31:0]        wr_data_i,
  input logic               win_hit_o,
  input logic [IDX_W-1:0]   win_idx_o,
  input logic               cs_o,
  input logic               no_hit_o,
  input logic [31:0]        fetch_vec_o,
  input logic [WIN_NUM-1:0] hit_vec_i
);
  // R9
  cs_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_o |-> win_hit_o);

  // R9
  miss_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_hit_o |-> no_hit_o);

  // R6
  prio_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_hit_o && win_idx_o != '0) |-> !hit_vec_i[0]);

  // R6
  idx_points_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_hit_o |-> hit_vec_i[win_idx_o]);

  // R1
  fetch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $stable(fetch_vec_o));

  // R5
  attr_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == SEL_W'(1) && !wr_data_i[31]) |=> !hit_vec_i[0]);
endmodule

bind boot_law_decoder boot_law_chk #(.WIN_NUM(WIN_NUM), .SEL_W(SEL_W), .IDX_W(IDX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_sel_i   (wr_sel_i),
  .wr_data_i  (wr_data_i),
  .win_hit_o  (win_hit_o),
  .win_idx_o  (win_idx_o),
  .cs_o       (cs_o),
  .no_hit_o   (no_hit_o),
  .fetch_vec_o(fetch_vec_o),
  .hit_vec_i  (win_hit_vec)
);

// File: tb/tb_boot_law_decoder.sv
module tb_boot_law_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_hi = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] addr = '0;
  logic        win_hit, cs, no_hit;
  logic [0:0]  win_idx;
  logic [31:0] fetch_vec;

  int checks = 0;
  int failures = 0;
  bit cmp_on = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  boot_law_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .boot_hi_i(boot_hi),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .addr_i(addr), .win_hit_o(win_hit), .win_idx_o(win_idx),
    .cs_o(cs), .no_hit_o(no_hit), .fetch_vec_o(fetch_vec)
  );

  // reference model
  bit          m_en [2];
  int          m_code [2];
  logic [31:0] m_base [2];
  logic [31:0] m_bbase, m_bmask;
  bit          m_hi;

  function automatic bit m_win(int i, logic [31:0] a);
    if (!m_en[i] || m_code[i] < 19) return 1'b0;
    return ((longint'(a ^ m_base[i]) >> (m_code[i] + 1)) == 0);
  endfunction

  function automatic bit m_bank(logic [31:0] a);
    return ((a ^ m_bbase) & m_bmask) == 32'h0;
  endfunction

  task automatic m_reset(bit hi);
    m_hi = hi;
    m_en[0] = 1'b1; m_code[0] = 22; m_base[0] = hi ? 32'hFF80_0000 : 32'h0;
    m_en[1] = 1'b0; m_code[1] = 0;  m_base[1] = 32'h0;
    m_bbase = hi ? 32'hFF80_0000 : 32'h0;
    m_bmask = 32'hFF80_0000;
  endtask

  always @(posedge clk) begin
    if (rst_n && wr_en) begin
      case (wr_sel)
        3'd0: m_base[0] = wr_data & 32'hFFFF_F000;
        3'd1: begin m_en[0] = wr_data[31]; m_code[0] = int'(wr_data[4:0]); end
        3'd2: m_base[1] = wr_data & 32'hFFFF_F000;
        3'd3: begin m_en[1] = wr_data[31]; m_code[1] = int'(wr_data[4:0]); end
        3'd4: m_bbase = wr_data & 32'hFFFF_8000;
        3'd5: m_bmask = wr_data & 32'hFFFF_8000;
        default: ;
      endcase
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      bit h0, h1, hit, bk;
      h0 = m_win(0, addr);
      h1 = m_win(1, addr);
      hit = h0 || h1;
      bk = m_bank(addr);
      chk("R3 model win_hit", 32'(win_hit), 32'(hit));
      if (hit) chk("R6 model win_idx", 32'(win_idx), h0 ? 32'd0 : 32'd1);
      chk("R9 model cs", 32'(cs), 32'(hit && bk));
      chk("R9 model no_hit", 32'(no_hit), 32'(!(hit && bk)));
      chk("R1 model fetch", fetch_vec, m_hi ? 32'hFFF0_0100 : 32'h0000_0100);
    end
  end

  task automatic do_reset(bit hi);
    @(negedge clk); #1;
    cmp_on = 1'b0;
    rst_n = 1'b0; boot_hi = hi; wr_en = 1'b0; addr = '0;
    m_reset(hi);
    repeat (2) @(negedge clk);
    #1 rst_n = 1'b1;
    cmp_on = 1'b1;
  endtask

  task automatic wr(logic [2:0] sel, logic [31:0] data);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic look(string tag, logic [31:0] a, bit e_hit, bit e_idx, bit e_cs);
    @(negedge clk); #1;
    addr = a;
    #1;
    chk(tag, 32'(win_hit), 32'(e_hit));
    if (e_hit) chk(tag, 32'(win_idx), 32'(e_idx));
    chk(tag, 32'(cs), 32'(e_cs));
    chk(tag, 32'(no_hit), 32'(!e_cs));
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // boot space 0
    do_reset(1'b0);
    #1 chk("R1 fetch lo", fetch_vec, 32'h0000_0100);
    look("R2 lo first fetch", 32'h0000_0100, 1, 0, 1);
    look("R2 lo top", 32'h007F_FFFF, 1, 0, 1);
    look("R2 lo past end", 32'h0080_0000, 0, 0, 0);
    look("R11 win1 off", 32'hFE00_0000, 0, 0, 0);

    // R6 overlapping windows
    wr(3'd2, 32'h0000_0000);
    wr(3'd3, 32'h8000_0013);
    look("R6 prio", 32'h0000_0100, 1, 0, 1);
    look("R6 prio inner", 32'h0008_0000, 1, 0, 1);

    // R4 high window with junk low base bits; bank mismatch
    wr(3'd2, 32'hFE12_3000);
    wr(3'd3, 32'h8000_0017);
    look("R4 base low ignored", 32'hFE00_0000, 1, 1, 0);
    look("R4 window top", 32'hFEFF_FFFF, 1, 1, 0);
    look("R3 16MB end", 32'hFF00_0000, 0, 0, 0);

    // R8 cleared mask
    wr(3'd5, 32'h0000_7FFF);
    look("R8 alias high", 32'hFE00_0000, 1, 1, 1);
    look("R8 no window", 32'h0123_4567, 0, 0, 0);
    look("R8 alias low", 32'h0000_0200, 1, 0, 1);

    // R3 size code limits and enable
    wr(3'd3, 32'h8000_0012);
    look("R3 code below min", 32'hFE00_0000, 0, 0, 0);
    wr(3'd3, 32'h0000_0013);
    look("R3 enable clear", 32'hFE00_0000, 0, 0, 0);
    wr(3'd2, 32'hFE00_0000);
    wr(3'd3, 32'h8000_0013);
    look("R3 1MB top", 32'hFE0F_FFFF, 1, 1, 1);
    look("R3 1MB end", 32'hFE10_0000, 0, 0, 0);

    // R7 bank compare on bits 31:15 only
    wr(3'd3, 32'h8000_0017);
    wr(3'd4, 32'hFE00_7FFF);
    wr(3'd5, 32'hFE00_0000);
    look("R7 bank match", 32'hFE12_3456, 1, 1, 1);
    look("R7 bank miss low", 32'h0000_0100, 1, 0, 0);
    wr(3'd4, 32'hFC00_0000);
    look("R7 bank moved", 32'hFE12_3456, 1, 1, 0);

    // R5 zero turns window off
    wr(3'd2, 32'h0);
    wr(3'd3, 32'h0);
    look("R5 window off", 32'hFE12_3456, 0, 0, 0);

    // R10 write and decode in the same cycle
    wr(3'd5, 32'h0000_0000);
    look("R10 before", 32'h0000_0100, 1, 0, 1);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_sel = 3'd1; wr_data = 32'h0;
    #1;
    chk("R10 same cycle hit", 32'(win_hit), 32'd1);
    chk("R10 same cycle cs", 32'(cs), 32'd1);
    @(negedge clk); #1;
    wr_en = 1'b0;
    #1;
    chk("R10 next cycle hit", 32'(win_hit), 32'd0);
    chk("R10 next cycle no_hit", 32'(no_hit), 32'd1);

    // boot space 1
    do_reset(1'b1);
    #1 chk("R1 fetch hi", fetch_vec, 32'hFFF0_0100);
    look("R2 hi first fetch", 32'hFFF0_0100, 1, 0, 1);
    look("R11 hi bank base", 32'hFF80_0000, 1, 0, 1);
    look("R2 hi below", 32'hFF7F_FFFF, 0, 0, 0);
    look("R2 hi low addr", 32'h0000_0100, 0, 0, 0);
    repeat (3) @(negedge clk);
    #1 chk("R1 fetch hold", fetch_vec, 32'hFFF0_0100);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule